// File: doc/BRIEF.md
# Four-Beat Double-Rate Burst SRAM Model

This block is a synthesizable stand-in for a separate-I/O burst SRAM. It holds a small on-chip array and exposes it through one shared address bus, a read select, a write select, a dedicated write-word input and a dedicated read-word output, plus a read-valid strobe. Everything runs on one fast clock at twice the device rate. Each fast cycle carries one data beat. Every second fast edge stands for a rising edge of the device clock.

The device-clock edges take turns between the read port and the write port. A read burst is started on one device edge and a write burst on the next. Each address names an aligned group of four words, and those words move in ascending order on four consecutive beats. Reads and writes run at the same time on their own data paths. A read also returns words from a write that is still being collected, when that write's address was taken before the read's data begins.

Top module: `qbs_burst_sram`

## Requirements
- R1: After reset is released, the first clock edge and then every fourth edge is a read address slot, with phase 0. The edge two after each read slot is a write address slot, with phase 2. No other edge captures an address.
- R2: A select that is low in its own slot starts no transfer. A select that is high outside its own slot is ignored. Neither case changes the array or the read output.
- R3: After a write address is captured, the next four edges take words 0, 1, 2 and 3 of the group from the write-word input. Word k is stored at word index group*4+k. The four words are committed together on the fourth of those edges.
- R4: After a read address is captured on edge E, the output registers are loaded on edges E+5 through E+8 with words 0, 1, 2 and 3 of the group, one per edge.
- R5: Read-valid is high only in the cycles where a read word is presented. In every other cycle it is low and the read-word output is all zeros.
- R6: Reads in consecutive read slots give read-valid bursts that follow each other without a gap cycle.
- R7: A read returns the words of a write whose address was captured in the write slot that follows the read's own address slot, including words that have not yet been committed to the array.
- R8: A write whose address is captured after the read's first output edge is not visible in any word of that read.
- R9: While reset is low, and in the first cycle after it, read-valid is low and the read-word output is zero.
- R10: A read and a write to different groups in the same four-edge frame do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, two beats per device-clock period |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | GROUP_AW | Shared group address, read on read slots and write on write slots |
| rd_sel | input | 1 | Read port select, active high, sampled on read slots |
| wr_sel | input | 1 | Write port select, active high, sampled on write slots |
| wr_word | input | WORD_W | Write data beat |
| rd_word | output | WORD_W | Read data beat, zero when not valid |
| rd_valid | output | 1 | High while rd_word carries a burst word |

## Verification
The bench drives both selects high on every edge outside their slots, with unrelated addresses. A design that decoded slots wrongly would then start extra bursts, and these would show up as stray valid cycles or as corrupted words in later reads. Some frames write the same group that the same frame reads. A design that read only the committed array would then return stale words for R7. Other frames write, in the next frame, the group just read. A forwarding path that is too eager would leak those words into the earlier read for R8. Back-to-back reads check that the valid strobe has no gap, and a read latency off by one shows up as shifted words on every burst.

// File: rtl/qbs_pkg.sv
// Shared constants for the burst SRAM model.
// Assumes a fixed four-beat burst and a phase counter of two bits.
package qbs_pkg;
    localparam int          BURST_LEN = 4;
    localparam int          BEAT_W    = 2;
    localparam logic [1:0]  PH_READ   = 2'd0;   // read address slot
    localparam logic [1:0]  PH_WRITE  = 2'd2;   // write address slot
endpackage

// File: rtl/qbs_phase_gen.sv
// Phase counter: counts fast cycles modulo four after reset.
// Phase 0 marks the read address slot and phase 2 the write address slot.
// Assumes reset is synchronous and active low.
module qbs_phase_gen (
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] phase
);
    // advance the phase once per fast cycle
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 2'd0;
        else        phase <= phase + 2'd1;
    end
endmodule

// File: rtl/qbs_array.sv
// Storage array: a four-word group write port and a word-wide read port.
// Assumes the contents need no reset. Reads see the committed contents only.
module qbs_array #(
    parameter int WORD_W   = 18,
    parameter int GROUP_AW = 4
) (
    input  logic                            clk,
    input  logic                            wr_en,
    input  logic [GROUP_AW-1:0]             wr_group,
    input  logic [qbs_pkg::BURST_LEN-1:0][WORD_W-1:0] wr_words,
    input  logic [GROUP_AW+1:0]             rd_index,
    output logic [WORD_W-1:0]               rd_data
);
    localparam int DEPTH = qbs_pkg::BURST_LEN << GROUP_AW;

    logic [WORD_W-1:0] mem [DEPTH];

    // commit a full group in one edge
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < qbs_pkg::BURST_LEN; b++) begin
                mem[{wr_group, 2'(b)}] <= wr_words[b];
            end
        end
    end

    assign rd_data = mem[rd_index];
endmodule

// File: rtl/qbs_write_path.sv
// Write path: captures the write group on the write slot, collects four
// beats on the following edges, and asks for a commit on the last one.
// Collected words are exposed with per-word presence flags for forwarding.
// Assumes that beat k of a burst lands on the edge where phase+1 equals k.
module qbs_write_path import qbs_pkg::*; #(
    parameter int WORD_W   = 18,
    parameter int GROUP_AW = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        phase,
    input  logic                              wr_sel,
    input  logic [GROUP_AW-1:0]               bus_addr,
    input  logic [WORD_W-1:0]                 wr_word,
    output logic [BURST_LEN-1:0][WORD_W-1:0]  wb_words,
    output logic [GROUP_AW-1:0]               wb_group,
    output logic [BURST_LEN-1:0]              wb_have,
    output logic                              commit,
    output logic [BURST_LEN-1:0][WORD_W-1:0]  commit_words
);
    logic              active;
    logic              take;
    logic [BEAT_W-1:0] beat;

    assign take = wr_sel && (phase == PH_WRITE);
    assign beat = phase + 2'd1;
    assign commit = active && (beat == 2'd3);

    // collect burst words and restart on a new capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            wb_group <= '0;
            wb_have  <= '0;
            wb_words <= '0;
        end else begin
            if (active) begin
                wb_words[beat] <= wr_word;
                wb_have[beat]  <= 1'b1;
                if (beat == 2'd3) active <= 1'b0;
            end
            if (take) begin
                active   <= 1'b1;
                wb_group <= bus_addr;
                wb_have  <= '0;
            end
        end
    end

    // the last word goes to the array straight from the input
    always_comb begin
        commit_words    = wb_words;
        commit_words[3] = wr_word;
    end

    // R3
    commit_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(take, 4));

    // R2
    no_write_outside_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WRITE) |=> $stable(wb_group));
endmodule

// File: rtl/qbs_read_path.sv
// Read path: holds a captured read group for one frame, then plays it out
// as four words, taking each word from the pending write buffer when that
// word has already arrived for the same group, otherwise from the array.
// Assumes reads are only accepted on phase 0, so one queued and one playing
// read is the most that can exist.
module qbs_read_path import qbs_pkg::*; #(
    parameter int WORD_W   = 18,
    parameter int GROUP_AW = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        phase,
    input  logic                              rd_sel,
    input  logic [GROUP_AW-1:0]               bus_addr,
    input  logic [BURST_LEN-1:0][WORD_W-1:0]  wb_words,
    input  logic [GROUP_AW-1:0]               wb_group,
    input  logic [BURST_LEN-1:0]              wb_have,
    input  logic [WORD_W-1:0]                 arr_word,
    output logic [GROUP_AW+1:0]               arr_index,
    output logic [WORD_W-1:0]                 rd_word,
    output logic                              rd_valid
);
    logic                q_live, l_live;
    logic [GROUP_AW-1:0] q_group, l_group;
    logic                take;
    logic                fwd;
    logic [BEAT_W-1:0]   beat;
    logic [WORD_W-1:0]   word;

    assign take = rd_sel && (phase == PH_READ);
    assign beat = phase - 2'd1;

    // queue a captured read, then launch it one frame later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_live  <= 1'b0;
            q_group <= '0;
            l_live  <= 1'b0;
            l_group <= '0;
        end else if (phase == PH_READ) begin
            l_live  <= q_live;
            l_group <= q_group;
            q_live  <= take;
            q_group <= bus_addr;
        end
    end

    // choose forwarded or stored word for the current beat
    always_comb begin
        arr_index = {l_group, beat};
        fwd       = wb_have[beat] && (wb_group == l_group);
        word      = fwd ? wb_words[beat] : arr_word;
    end

    // register the output beat and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= l_live;
            rd_word  <= l_live ? word : '0;
        end
    end

    // R4
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ##6 rd_valid);

    // R4
    valid_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(take, 6));

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_word == '0));

    // R6
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> ##3 rd_valid);
endmodule

// File: rtl/qbs_burst_sram.sv
// Top of the burst SRAM model: phase counter, write collector, read player
// and storage array. One fast clock, two beats per device period.
// Assumes the caller aligns commands to the phase that starts at reset release.
module qbs_burst_sram import qbs_pkg::*; #(
    parameter int WORD_W   = 18,
    parameter int GROUP_AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GROUP_AW-1:0] bus_addr,
    input  logic                rd_sel,
    input  logic                wr_sel,
    input  logic [WORD_W-1:0]   wr_word,
    output logic [WORD_W-1:0]   rd_word,
    output logic                rd_valid
);
    logic [1:0]                       phase;
    logic [BURST_LEN-1:0][WORD_W-1:0] wb_words;
    logic [BURST_LEN-1:0][WORD_W-1:0] commit_words;
    logic [GROUP_AW-1:0]              wb_group;
    logic [BURST_LEN-1:0]             wb_have;
    logic                             commit;
    logic [GROUP_AW+1:0]              arr_index;
    logic [WORD_W-1:0]                arr_word;

    qbs_phase_gen i_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    qbs_write_path #(.WORD_W(WORD_W), .GROUP_AW(GROUP_AW)) i_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase        (phase),
        .wr_sel       (wr_sel),
        .bus_addr     (bus_addr),
        .wr_word      (wr_word),
        .wb_words     (wb_words),
        .wb_group     (wb_group),
        .wb_have      (wb_have),
        .commit       (commit),
        .commit_words (commit_words)
    );

    qbs_array #(.WORD_W(WORD_W), .GROUP_AW(GROUP_AW)) i_arr (
        .clk      (clk),
        .wr_en    (commit),
        .wr_group (wb_group),
        .wr_words (commit_words),
        .rd_index (arr_index),
        .rd_data  (arr_word)
    );

    qbs_read_path #(.WORD_W(WORD_W), .GROUP_AW(GROUP_AW)) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .rd_sel    (rd_sel),
        .bus_addr  (bus_addr),
        .wb_words  (wb_words),
        .wb_group  (wb_group),
        .wb_have   (wb_have),
        .arr_word  (arr_word),
        .arr_index (arr_index),
        .rd_word   (rd_word),
        .rd_valid  (rd_valid)
    );

    // R1
    commit_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (phase == PH_WRITE));
endmodule

// File: tb/test_qbs_burst_sram.sv
module test_qbs_burst_sram;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int AW = 3;
    localparam int F  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          rd_sel = 1'b0;
    logic          wr_sel = 1'b0;
    logic [W-1:0]  wr_word = '0;
    logic [W-1:0]  rd_word;
    logic          rd_valid;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    bit            rd_en [F];
    bit            wr_en [F];
    logic [AW-1:0] raddr [F];
    logic [AW-1:0] waddr [F];
    logic [W-1:0]  expw  [F][4];
    logic [W-1:0]  model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    qbs_burst_sram #(.WORD_W(W), .GROUP_AW(AW)) i_qbs_burst_sram (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .rd_sel   (rd_sel),
        .wr_sel   (wr_sel),
        .wr_word  (wr_word),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );

    function automatic logic [W-1:0] wdat(int j, int b);
        return W'(j*13 + b*5 + 7);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD*200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // build the frame plan and the expected read words
        for (int j = 0; j < F; j++) begin
            if (j < 8) begin
                rd_en[j] = 1'b0; raddr[j] = '0;
                wr_en[j] = 1'b1; waddr[j] = AW'(j);
            end else begin
                rd_en[j] = (j % 7) != 3;
                raddr[j] = AW'((j*3) % 8);
                wr_en[j] = (j % 5) != 2;
                if (j % 3 == 0)      waddr[j] = raddr[j];
                else if (j % 3 == 1) waddr[j] = AW'(((j-1)*3) % 8);
                else                 waddr[j] = AW'((j*5 + 1) % 8);
            end
        end
        for (int j = 0; j < F; j++) begin
            if (wr_en[j]) for (int b = 0; b < 4; b++) model[waddr[j]*4 + b] = wdat(j, b);
            if (rd_en[j]) for (int b = 0; b < 4; b++) expw[j][b] = model[raddr[j]*4 + b];
        end

        // reset, with selects high to show reset wins (R9)
        rd_sel = 1'b1; wr_sel = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 valid", 32'(rd_valid), 0);
        chk("R9 data", 32'(rd_word), 0);

        for (int t = 0; t < 4*F + 12; t++) begin
            int s, jr, b, c, jw, bw;
            bit live;
            string vtag, dtag;
            @(negedge clk);
            if (t == 0) rst_n = 1'b1;
            // outputs now show the result of edge t-1
            if (t == 0) begin
                chk("R9 valid", 32'(rd_valid), 0);
                chk("R9 data", 32'(rd_word), 0);
            end else begin
                s = t - 1; live = 1'b0; jr = 0; b = 0;
                if (s >= 5) begin
                    jr = (s - 5) / 4; b = (s - 5) % 4;
                    if (jr < F && rd_en[jr]) live = 1'b1;
                end
                if (!live) begin
                    vtag = (s >= 5 && jr < F) ? "R2 valid" : "R5 valid";
                    dtag = "R5 data";
                end else begin
                    vtag = (b == 0 && jr > 0 && rd_en[jr-1]) ? "R1/R6 valid" : "R1/R4 valid";
                    if (wr_en[jr] && waddr[jr] == raddr[jr])
                        dtag = "R7 data";
                    else if (jr + 1 < F && wr_en[jr+1] && waddr[jr+1] == raddr[jr])
                        dtag = "R8 data";
                    else
                        dtag = "R3/R4/R10 data";
                end
                chk(vtag, 32'(rd_valid), 32'(live));
                chk(dtag, 32'(rd_word), live ? 32'(expw[jr][b]) : 0);
            end
            // drive the inputs for edge t; off-slot selects stay high (R2)
            c = t % 4; jw = 0; bw = 0;
            bus_addr = AW'(t*5 + 3);
            rd_sel = 1'b1; wr_sel = 1'b1;
            if (c == 0) begin
                rd_sel = (t/4 < F) ? rd_en[t/4] : 1'b0;
                if (t/4 < F) bus_addr = raddr[t/4];
            end
            if (c == 2) begin
                wr_sel = (t/4 < F) ? wr_en[t/4] : 1'b0;
                if (t/4 < F) bus_addr = waddr[t/4];
            end
            wr_word = W'(t*29 + 3);
            if (t >= 3) begin
                jw = (t - 3) / 4; bw = (t - 3) % 4;
                if (jw < F && wr_en[jw]) wr_word = wdat(jw, bw);
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule